// File: doc/BRIEF.md
# Selectable-Pin Interrupt Channel Unit

This block turns up to eight chosen general-purpose inputs into eight separate interrupt requests. Each channel holds a select field naming one port and one pin out of a flat input bus of 8 ports by 32 pins. The chosen bit passes through a two-flop synchroniser. It then drives an edge detector or a level qualifier, depending on that channel's mode bit.

In edge mode a qualifying transition sets a sticky status bit. The interrupt stays high until software clears the bit by writing 1 to it. In level mode the interrupt follows the synchronised level of the input directly. The two enable bits then choose whether a high level, a low level or both count as active. When a select field is rewritten, the channel's status is cleared. Edge detection is also held off until the synchroniser carries only samples from the new source.

Configuration is through a plain single-cycle register port. A write happens on a clock edge when `reg_we` is high. Read data is combinational from `reg_addr`.

Top module: `pinint_unit`

## Requirements
- R1: After reset every register reads 0, every `irq` bit is 0, and every channel selects port 0 pin 0.
- R2: The two select registers, address 0 and address 1, read back the full 32 bits written. Address 2 (mode), address 3 (rise enable) and address 4 (fall enable) keep bits [7:0] and read 0 in bits [31:8].
- R3: Channel k's select field is 8 bits at register k/4, bits [8*(k%4)+7 : 8*(k%4)]. Its pin is bits [4:0] and its port is bits [7:5]. The source is `gpio_in[port*32+pin]`, and no other input bit affects the channel.
- R4: In edge mode (mode bit 0) with rise enable 1, a 0-to-1 change of the source sets the channel's status. `irq` rises after the third rising clock edge that follows the input change.
- R5: In edge mode with fall enable 1, a 1-to-0 change of the source sets the status with the same three-edge latency.
- R6: A transition whose direction is not enabled sets no status. With both enables set, either direction sets it.
- R7: Status is sticky. Writing 1 to a bit of the status register (address 5) clears that bit. Writing 0 has no effect. If a new edge is detected in the same cycle as the clear, the status stays set.
- R8: In level mode (mode bit 1), `irq` is high when the source is high and rise enable is 1, or when the source is low and fall enable is 1. This follows the source with two edges of latency. Level mode never sets status.
- R9: A write that changes a channel's select field clears its status on that edge. No edge is recognised on the next three clock edges, so switching source raises no false event.
- R10: Reading address 5 returns the eight status bits in bits [7:0] and 0 above.
- R11: Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| gpio_in | input | 256 | Flat input bus, port p pin n at bit p*32+n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 8 | One interrupt request per channel |

## Verification
A corrupted select field shows up right away when the register is read back. It also shows up at the ports within three edges, as an `irq` that either ignores its own pin or reacts to a foreign one. A status bit that is lost or set wrongly shows on `irq` in edge mode on the very next cycle. A synchroniser history or hold-off count that is wrong only shows at a source switch or an edge. It appears as a spurious or missing event three edges after the input moves. The reference model is compared against `irq` on every cycle, including a long stretch of random pin toggles, clears and source switches, so such faults are caught within a few cycles.

// File: rtl/pinint_pkg.sv
package pinint_pkg;
  localparam int NCH      = 8;
  localparam int PORT_W   = 3;
  localparam int PIN_W    = 5;
  localparam int FIELD_W  = PORT_W + PIN_W;
  localparam int SRC_W    = 1 << FIELD_W;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int PER_REG  = DATA_W / FIELD_W;
  localparam int NSEL_REG = NCH / PER_REG;
  localparam int QUIET    = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SEL0 = 3'd0,
    A_SEL1 = 3'd1,
    A_MODE = 3'd2,
    A_RISE = 3'd3,
    A_FALL = 3'd4,
    A_STAT = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/pinint_cfg.sv
module pinint_cfg
  import pinint_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NCH-1:0]          stat,
  output logic [NCH*FIELD_W-1:0]  sel,
  output logic [NCH-1:0]          mode,
  output logic [NCH-1:0]          rise_en,
  output logic [NCH-1:0]          fall_en,
  output logic [NCH-1:0]          chg,
  output logic [NCH-1:0]          clr,
  output logic [DATA_W-1:0]       rdata
);
  localparam int SELBITS = NSEL_REG * DATA_W;

  logic [SELBITS-1:0] sel_q, sel_d;
  logic [NCH-1:0]     mode_q, mode_d, rise_q, rise_d, fall_q, fall_d;

  // next state
  always_comb begin
    sel_d  = sel_q;
    mode_d = mode_q;
    rise_d = rise_q;
    fall_d = fall_q;
    for (int r = 0; r < NSEL_REG; r++) begin
      if (we && addr == ADDR_W'(r)) sel_d[r*DATA_W +: DATA_W] = wdata;
    end
    if (we) begin
      case (addr)
        A_MODE:  mode_d = wdata[NCH-1:0];
        A_RISE:  rise_d = wdata[NCH-1:0];
        A_FALL:  fall_d = wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      chg[k] = sel_d[k*FIELD_W +: FIELD_W] != sel_q[k*FIELD_W +: FIELD_W];
    end
    clr = (we && addr == A_STAT) ? wdata[NCH-1:0] : '0;
  end

  // registers, clock-enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mode_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (we) begin
      sel_q  <= sel_d;
      mode_q <= mode_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NSEL_REG; r++) begin
      if (addr == ADDR_W'(r)) rdata = sel_q[r*DATA_W +: DATA_W];
    end
    case (addr)
      A_MODE:  rdata = DATA_W'(mode_q);
      A_RISE:  rdata = DATA_W'(rise_q);
      A_FALL:  rdata = DATA_W'(fall_q);
      A_STAT:  rdata = DATA_W'(stat);
      default: ;
    endcase
  end

  assign sel     = sel_q[NCH*FIELD_W-1:0];
  assign mode    = mode_q;
  assign rise_en = rise_q;
  assign fall_en = fall_q;
endmodule

// File: rtl/pinint_chan.sv
module pinint_chan
  import pinint_pkg::*;
#(
  parameter int SRCS  = SRC_W,
  parameter int FW    = FIELD_W,
  parameter int HOLD  = QUIET,
  localparam int QW   = $clog2(HOLD + 1)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SRCS-1:0] src,
  input  logic [FW-1:0]   sel,
  input  logic            chg,
  input  logic            mode,
  input  logic            rise_en,
  input  logic            fall_en,
  input  logic            clr,
  output logic            irq,
  output logic            stat
);
  logic          s1_q, s2_q, s3_q;
  logic          stat_q, stat_d;
  logic [QW-1:0] quiet_q, quiet_d;
  logic          tap, rise_hit, fall_hit, edge_hit;

  always_comb begin
    tap      = src[sel];
    rise_hit = s2_q & ~s3_q;
    fall_hit = ~s2_q & s3_q;
    edge_hit = ~mode & (quiet_q == '0) &
               ((rise_en & rise_hit) | (fall_en & fall_hit));
    if (chg)           stat_d = 1'b0;
    else if (edge_hit) stat_d = 1'b1;
    else if (clr)      stat_d = 1'b0;
    else               stat_d = stat_q;
    if (chg)                 quiet_d = QW'(HOLD);
    else if (quiet_q != '0)  quiet_d = quiet_q - 1'b1;
    else                     quiet_d = quiet_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      s3_q    <= 1'b0;
      stat_q  <= 1'b0;
      quiet_q <= '0;
    end else begin
      s1_q    <= tap;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      stat_q  <= stat_d;
      quiet_q <= quiet_d;
    end
  end

  assign irq  = mode ? ((rise_en & s2_q) | (fall_en & ~s2_q)) : stat_q;
  assign stat = stat_q;
endmodule

// File: rtl/pinint_unit.sv
module pinint_unit
  import pinint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  gpio_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    irq
);
  logic [NCH*FIELD_W-1:0] sel_v;
  logic [NCH-1:0]         mode_v, rise_v, fall_v, chg_v, clr_v, stat_v;

  pinint_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .stat    (stat_v),
    .sel     (sel_v),
    .mode    (mode_v),
    .rise_en (rise_v),
    .fall_en (fall_v),
    .chg     (chg_v),
    .clr     (clr_v),
    .rdata   (reg_rdata)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    pinint_chan u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (gpio_in),
      .sel     (sel_v[k*FIELD_W +: FIELD_W]),
      .chg     (chg_v[k]),
      .mode    (mode_v[k]),
      .rise_en (rise_v[k]),
      .fall_en (fall_v[k]),
      .clr     (clr_v[k]),
      .irq     (irq[k]),
      .stat    (stat_v[k])
    );
  end
endmodule

// File: rtl/pinint_unit_chk.sv
module pinint_unit_chk
  import pinint_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NCH-1:0]    stat_v,
  input logic [NCH-1:0]    mode_v,
  input logic [NCH-1:0]    clr_v,
  input logic [NCH-1:0]    chg_v
);
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(stat_v) | stat_v | $past(clr_v | chg_v)) == '1)); // R7

  AST_SELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_v != '0) |=> ((stat_v & $past(chg_v)) == '0)); // R9

  AST_QUIET_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_v & ~$past(stat_v) & $past(chg_v, 2)) == '0)); // R9

  AST_LEVEL_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_v & ~$past(stat_v) & $past(mode_v)) == '0)); // R8

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(A_STAT)) |-> (reg_rdata == '0)); // R11
endmodule

bind pinint_unit pinint_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .stat_v    (stat_v),
  .mode_v    (mode_v),
  .clr_v     (clr_v),
  .chg_v     (chg_v)
);

// File: tb/pinint_unit_test.sv
module pinint_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [255:0] gpio;
  logic        we;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  irq;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 0;
  bit done   = 0;

  pinint_unit uut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio), .reg_we(we),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit [63:0] selm;
  bit [7:0]  modem, risem, fallm, stm;
  bit        hist[NC][3];
  int        quiet[NC];

  function automatic int srcof(int c);
    return int'(selm[c*8 +: 8]);
  endfunction

  function automatic bit [7:0] exp_irq();
    bit [7:0] e;
    for (int c = 0; c < NC; c++) begin
      if (modem[c]) e[c] = (risem[c] && hist[c][1]) || (fallm[c] && !hist[c][1]);
      else          e[c] = stm[c];
    end
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selm = '0; modem = '0; risem = '0; fallm = '0; stm = '0;
      for (int c = 0; c < NC; c++) begin
        hist[c][0] = 0; hist[c][1] = 0; hist[c][2] = 0; quiet[c] = 0;
      end
    end else begin
      bit [63:0] nsel;
      nsel = selm;
      if (we && addr == 3'd0) nsel[31:0]  = wdata;
      if (we && addr == 3'd1) nsel[63:32] = wdata;
      for (int c = 0; c < NC; c++) begin
        bit ev, sw;
        ev = !modem[c] && quiet[c] == 0 &&
             ((risem[c] && hist[c][1] && !hist[c][2]) ||
              (fallm[c] && !hist[c][1] && hist[c][2]));
        sw = nsel[c*8 +: 8] != selm[c*8 +: 8];
        if (sw)      stm[c] = 0;
        else if (ev) stm[c] = 1;
        else if (we && addr == 3'd5 && wdata[c]) stm[c] = 0;
        if (sw) quiet[c] = 3;
        else if (quiet[c] > 0) quiet[c]--;
        hist[c][2] = hist[c][1];
        hist[c][1] = hist[c][0];
        hist[c][0] = gpio[srcof(c)];
      end
      selm = nsel;
      if (we && addr == 3'd2) modem = wdata[7:0];
      if (we && addr == 3'd3) risem = wdata[7:0];
      if (we && addr == 3'd4) fallm = wdata[7:0];
    end
  end

  // every-cycle comparison of the interrupt outputs
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      checks++;
      if (irq !== exp_irq()) begin
        errors++;
        $display("FAIL R4/R5/R6/R7/R8/R9 irq model mismatch: actual=%h expected=%h at %0t",
                 irq, exp_irq(), $time);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0; addr = 3'd0; wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // channel k -> port k, pin (3k+1)%32
  function automatic logic [7:0] fld(int k);
    return {3'(k), 5'((3*k+1) % 32)};
  endfunction
  function automatic int idx(int k);
    return k*32 + (3*k+1) % 32;
  endfunction

  initial begin
    rst_n = 1; gpio = '0; we = 0; addr = '0; wdata = '0;
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    // R1 reset state
    check("R1 irq after reset", 32'(irq), 32'h0);
    for (int a = 0; a < 6; a++) rd(3'(a), 32'h0, "R1 register after reset");
    cmp_on = 1;

    // R2 / R3 select layout and readback
    wr(3'd0, {fld(3), fld(2), fld(1), fld(0)});
    wr(3'd1, {fld(7), fld(6), fld(5), fld(4)});
    rd(3'd0, {fld(3), fld(2), fld(1), fld(0)}, "R2 select register 0 readback");
    rd(3'd1, {fld(7), fld(6), fld(5), fld(4)}, "R2 select register 1 readback");
    wr(3'd2, 32'hFFFF_FF00);
    rd(3'd2, 32'h0000_0000, "R2 mode upper bits read 0");
    wr(3'd3, 32'hA5A5_A5FF);
    rd(3'd3, 32'h0000_00FF, "R2 rise enable keeps low byte");
    tick(5);

    // R4 rising edge latency on channel 0
    gpio[idx(0)] = 1;
    tick(2);
    check("R4 no irq after two edges", 32'(irq[0]), 32'h0);
    tick(1);
    check("R4 irq after third edge", 32'(irq[0]), 32'h1);
    // R10 status read
    rd(3'd5, 32'h0000_0001, "R10 status register");
    // R7 writing 0 has no effect, writing 1 clears
    wr(3'd5, 32'h0000_00FE);
    check("R7 write 0 keeps status", 32'(irq[0]), 32'h1);
    wr(3'd5, 32'h0000_0001);
    check("R7 write 1 clears status", 32'(irq[0]), 32'h0);

    // R3 a foreign pin on channel 1's port does not affect channel 1
    gpio[idx(1) + 1] = 1;
    tick(5);
    check("R3 neighbouring pin ignored", 32'(irq[1]), 32'h0);
    gpio[idx(1)] = 1;
    tick(3);
    check("R3 selected pin drives channel 1", 32'(irq[1]), 32'h1);

    // R6 falling with only rise enabled: no status
    wr(3'd5, 32'hFF);
    gpio[idx(2)] = 1;
    tick(4);
    wr(3'd5, 32'hFF);
    gpio[idx(2)] = 0;
    tick(5);
    check("R6 disabled direction ignored", 32'(irq[2]), 32'h0);

    // R5 falling edge
    wr(3'd3, 32'h0);
    wr(3'd4, 32'hFF);
    gpio[idx(0)] = 0;
    tick(3);
    check("R5 falling edge sets irq", 32'(irq[0]), 32'h1);
    // R6 both enabled: rising on channel 3
    wr(3'd3, 32'hFF);
    wr(3'd5, 32'hFF);
    gpio[idx(3)] = 1;
    tick(3);
    check("R6 both enables catch rise", 32'(irq[3]), 32'h1);

    // R8 level mode on channel 4
    wr(3'd5, 32'hFF);
    wr(3'd3, 32'h10);
    wr(3'd4, 32'h00);
    wr(3'd2, 32'h10);
    check("R8 level low inactive", 32'(irq[4]), 32'h0);
    gpio[idx(4)] = 1;
    tick(1);
    check("R8 level one edge too early", 32'(irq[4]), 32'h0);
    tick(1);
    check("R8 level follows high", 32'(irq[4]), 32'h1);
    rd(3'd5, 32'h0, "R8 level mode sets no status");
    wr(3'd2, 32'h00);
    wr(3'd3, 32'hFF);
    wr(3'd4, 32'hFF);
    tick(4);
    wr(3'd5, 32'hFF);

    // R9 source switch clears status and raises no false edge
    gpio[idx(5)] = 1;
    tick(3);
    check("R9 status before switch", 32'(irq[5]), 32'h1);
    wr(3'd1, {fld(7), fld(6), 8'hE0, fld(4)});  // ch5 -> port 7 pin 0 (low)
    check("R9 switch clears status", 32'(irq[5]), 32'h0);
    tick(6);
    check("R9 no false edge after switch", 32'(irq[5]), 32'h0);

    // R11 unmapped addresses
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, 32'h0, "R11 address 6 reads 0");
    rd(3'd7, 32'h0, "R11 address 7 reads 0");
    rd(3'd2, 32'h0, "R11 mode untouched");
    rd(3'd1, {fld(7), fld(6), 8'hE0, fld(4)}, "R11 select untouched");

    // random phase: model comparison every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
        if ($urandom_range(0, 5) == 0) gpio[srcof(c)] = ~gpio[srcof(c)];
      end
      case ($urandom_range(0, 40))
        0: begin we = 1; addr = 3'd5; wdata = $urandom; end
        1: begin we = 1; addr = 3'd2; wdata = $urandom; end
        2: begin we = 1; addr = 3'd3; wdata = $urandom; end
        3: begin we = 1; addr = 3'd4; wdata = $urandom; end
        4: begin we = 1; addr = 3'(i % 2); wdata = $urandom; end
        default: begin we = 0; addr = 3'd0; wdata = '0; end
      endcase
    end
    @(negedge clk) we = 0;
    tick(4);
    rd(3'd5, 32'(stm), "R10 status after random phase");
    cmp_on = 0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule